// File: doc/BRIEF.md
# Frame Classifier with Four-Tuple Target Table

This block watches a byte-wide stream of an Ethernet frame, one byte per accepted cycle, starting at a marked first byte. It checks that the frame carries IPv4 inside an Ethernet II header, and that the IPv4 packet carries TCP or UDP. From the frame it takes the source and destination addresses, the two transport ports and the IP identification field. It then gives exactly one verdict per frame: forward the frame unchanged, encrypt it, decrypt it, or take it as a configuration packet. The verdict comes with the byte offset where the transport payload begins, since only that payload is transformed later, and with the identification field as a seed for the salt.

A side input tells the block which port the frame came from. When the four-tuple of a frame from the protected (red) side equals one of the stored targets, the verdict is encrypt. When the four-tuple of a frame from the network (black) side equals a target, the verdict is decrypt. A UDP packet from the red side addressed to 10.10.10.10 is a configuration packet. Its payload holds a new key and three new targets, and these overwrite the key and the whole target table at once.

Top module: `pkt_classifier`

## Requirements
- R1: After reset, `verdict_valid` is 0, `cfg_key` is zero and `cfg_tgt` is zero.
- R2: Frame bytes are indexed from 0 at the byte marked by `in_sop`. If bytes 12 and 13 are not 0x08, 0x00, the block gives verdict forward (code 0) in the cycle after byte 13. If the high nibble of byte 14 is not 4, or its low nibble (IHL) is below 5, the block gives forward in the cycle after byte 14.
- R3: If byte 23 (protocol) is neither 6 (TCP) nor 17 (UDP), the block gives forward in the cycle after byte 23.
- R4: The transport header starts at T = 14 + 4*IHL. For UDP, the verdict appears in the cycle after byte T+7, and `payload_off` is T+8.
- R5: For TCP, the verdict appears in the cycle after byte T+12. Let D be the high nibble of byte T+12. Then `payload_off` is T+4*D. If D is below 5, the verdict is forward.
- R6: The frame tuple is made of the source IP (bytes 26..29), the destination IP (bytes 30..33), the source port (T, T+1) and the destination port (T+2, T+3), all most significant byte first. If all four fields equal one stored target, the verdict is encrypt (code 1) when `in_side`=0 and decrypt (code 2) when `in_side`=1. With no match, the verdict is forward.
- R7: A UDP frame from `in_side`=0 whose destination IP is 0x0A0A0A0A gets the configuration verdict (code 3), whatever the table holds. A frame like this from `in_side`=1 is classified as in R6.
- R8: The configuration payload starts at T+8 and is 44 bytes long: a 7-byte key (most significant byte first), one pad byte, then targets 0, 1 and 2. Each target is 12 bytes: source IP, destination IP, source port, destination port. One cycle after the 44th payload byte, `cfg_key` and all of `cfg_tgt` take the new values together. Target j sits in `cfg_tgt[96*j +: 96]` as {src IP, dst IP, src port, dst port}. A configuration frame that ends before its 44th payload byte leaves the configuration unchanged.
- R9: A frame that ends (`in_eop`) before its deciding byte gets verdict forward in the cycle after its last byte. This includes a one-byte frame.
- R10: With a non-forward verdict, `salt_seed` carries bytes 18..19 (most significant byte first). With a forward verdict, `payload_off` and `salt_seed` are both 0.
- R11: Each frame gets exactly one one-cycle `verdict_valid` pulse. Bytes with `in_valid` high between the end of one frame and the next `in_sop` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| in_valid | input | 1 | A byte is present on `in_data` |
| in_sop | input | 1 | Marks byte 0 of a frame |
| in_eop | input | 1 | Marks the last byte of a frame |
| in_data | input | 8 | Frame byte |
| in_side | input | 1 | Ingress side, held for the frame: 0 red, 1 black |
| verdict_valid | output | 1 | One-cycle verdict pulse |
| verdict | output | 2 | 0 forward, 1 encrypt, 2 decrypt, 3 configuration |
| payload_off | output | 11 | Byte index of the first transport payload byte |
| salt_seed | output | 16 | IP identification of the frame |
| cfg_key | output | 56 | Current key |
| cfg_tgt | output | 288 | Current target table, three 96-bit tuples |

## Verification
On every cycle, the embedded assertions check four things. An encrypt verdict only follows a red-side byte, and a decrypt verdict only follows a black-side byte. A configuration verdict always points at a payload offset past the minimum headers. A verdict or a configuration change only ever follows an accepted byte. The deciding cycle for each header layout cannot be seen by the assertions and comes only from the bench's scenarios. The same holds for the payload offsets for IHL and TCP data-offset values, for matches on all four tuple fields, for partial mismatches and for table replacement. So do truncated frames, stray bytes outside a frame and a cut-off configuration packet.

// File: rtl/pkt_cls_pkg.sv
package pkt_cls_pkg;
   typedef enum logic [1:0] {
      VERD_FWD = 2'd0,
      VERD_ENC = 2'd1,
      VERD_DEC = 2'd2,
      VERD_ADM = 2'd3
   } verdict_e;

   typedef struct packed {
      logic [31:0] sip;
      logic [31:0] dip;
      logic [15:0] sport;
      logic [15:0] dport;
   } tuple_t;

   localparam int TUPLE_W = 96;
endpackage

// File: rtl/pkt_cls_parse.sv
module pkt_cls_parse
   import pkt_cls_pkg::*;
#(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sop,
   input  logic             in_eop,
   input  logic [7:0]       in_data,
   output logic             take,
   output logic             dec_now,
   output logic             dec_class,
   output logic             is_udp,
   output tuple_t           tup,
   output logic [15:0]      ident,
   output logic [CNT_W-1:0] pay_off
);
   logic [CNT_W-1:0] cnt_q, idx, tofs_q;
   logic             active_q, done_q, udp_q, tcp_q;
   logic [7:0]       b12_q;
   tuple_t           tup_q;
   logic [15:0]      id_q;

   assign take   = in_valid && (in_sop || active_q);
   assign idx    = in_sop ? '0 : cnt_q;
   assign is_udp = udp_q;
   assign tup    = tup_q;
   assign ident  = id_q;

   always_comb begin
      dec_now   = 1'b0;
      dec_class = 1'b0;
      pay_off   = '0;
      if (take && (in_sop || !done_q)) begin
         if (idx == CNT_W'(13) && {b12_q, in_data} != 16'h0800)
            dec_now = 1'b1;
         else if (idx == CNT_W'(14) && (in_data[7:4] != 4'd4 || in_data[3:0] < 4'd5))
            dec_now = 1'b1;
         else if (idx == CNT_W'(23) && in_data != 8'd6 && in_data != 8'd17)
            dec_now = 1'b1;
         else if (udp_q && idx == tofs_q + CNT_W'(7)) begin
            dec_now   = 1'b1;
            dec_class = 1'b1;
            pay_off   = tofs_q + CNT_W'(8);
         end else if (tcp_q && idx == tofs_q + CNT_W'(12)) begin
            dec_now   = 1'b1;
            dec_class = (in_data[7:4] >= 4'd5);
            pay_off   = tofs_q + CNT_W'({in_data[7:4], 2'b00});
         end
         if (!dec_now && in_eop)
            dec_now = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         tofs_q   <= CNT_W'(34);
         active_q <= 1'b0;
         done_q   <= 1'b0;
         udp_q    <= 1'b0;
         tcp_q    <= 1'b0;
         b12_q    <= '0;
         tup_q    <= '0;
         id_q     <= '0;
      end else if (take) begin
         cnt_q    <= (&idx) ? idx : idx + CNT_W'(1);
         active_q <= !in_eop;
         done_q   <= dec_now || (!in_sop && done_q);
         if (in_sop) begin
            udp_q <= 1'b0;
            tcp_q <= 1'b0;
         end else if (idx == CNT_W'(23)) begin
            udp_q <= (in_data == 8'd17);
            tcp_q <= (in_data == 8'd6);
         end
         if (idx == CNT_W'(12)) b12_q <= in_data;
         if (idx == CNT_W'(14)) tofs_q <= CNT_W'(14) + CNT_W'({in_data[3:0], 2'b00});
         if (idx == CNT_W'(18) || idx == CNT_W'(19)) id_q <= {id_q[7:0], in_data};
         if (idx >= CNT_W'(26) && idx <= CNT_W'(29)) tup_q.sip <= {tup_q.sip[23:0], in_data};
         if (idx >= CNT_W'(30) && idx <= CNT_W'(33)) tup_q.dip <= {tup_q.dip[23:0], in_data};
         if (idx == tofs_q || idx == tofs_q + CNT_W'(1))
            tup_q.sport <= {tup_q.sport[7:0], in_data};
         if (idx == tofs_q + CNT_W'(2) || idx == tofs_q + CNT_W'(3))
            tup_q.dport <= {tup_q.dport[7:0], in_data};
      end
   end

   // R3: a classifiable decision only after a TCP or UDP protocol byte
   assert_class_needs_l4_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_now && dec_class) |-> (udp_q || tcp_q));
endmodule

// File: rtl/pkt_cls_match.sv
module pkt_cls_match
   import pkt_cls_pkg::*;
#(
   parameter int NUM_TGT = 3
) (
   input  tuple_t                      pkt,
   input  logic [NUM_TGT*TUPLE_W-1:0]  table_in,
   output logic                        hit
);
   logic [NUM_TGT-1:0] hits;

   for (genvar j = 0; j < NUM_TGT; j++) begin : g_cmp
      assign hits[j] = (table_in[j*TUPLE_W +: TUPLE_W] == pkt);
   end

   assign hit = |hits;
endmodule

// File: rtl/pkt_cls_cfg.sv
module pkt_cls_cfg
   import pkt_cls_pkg::*;
#(
   parameter int NUM_TGT = 3,
   parameter int KEY_W   = 56
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       take,
   input  logic                       in_sop,
   input  logic                       in_eop,
   input  logic [7:0]                 in_data,
   input  logic                       start,
   output logic [KEY_W-1:0]           key,
   output logic [NUM_TGT*TUPLE_W-1:0] tgt
);
   localparam int ADM_BYTES = KEY_W/8 + 1 + NUM_TGT*(TUPLE_W/8);
   localparam int PAY_W     = ADM_BYTES*8;
   localparam int IDX_W     = $clog2(ADM_BYTES);
   localparam int TBL_TOP   = PAY_W - KEY_W - 9;

   logic             run_q, commit;
   logic [IDX_W-1:0] k_q;
   logic [PAY_W-9:0] sh_q;
   logic [PAY_W-1:0] full;

   assign commit = run_q && take && !in_sop && (k_q == IDX_W'(ADM_BYTES-1));
   assign full   = {sh_q, in_data};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         k_q   <= '0;
         sh_q  <= '0;
         key   <= '0;
         tgt   <= '0;
      end else begin
         if (start) begin
            run_q <= 1'b1;
            k_q   <= '0;
         end else if (run_q && take) begin
            if (in_sop) run_q <= 1'b0;
            else begin
               sh_q <= {sh_q[PAY_W-17:0], in_data};
               k_q  <= k_q + IDX_W'(1);
               if (commit || in_eop) run_q <= 1'b0;
            end
         end
         if (commit) begin
            key <= full[PAY_W-1 -: KEY_W];
            for (int j = 0; j < NUM_TGT; j++)
               tgt[j*TUPLE_W +: TUPLE_W] <= full[TBL_TOP - j*TUPLE_W -: TUPLE_W];
         end
      end
   end
endmodule

// File: rtl/pkt_classifier.sv
module pkt_classifier
   import pkt_cls_pkg::*;
#(
   parameter int          NUM_TGT  = 3,
   parameter int          KEY_W    = 56,
   parameter int          CNT_W    = 11,
   parameter logic [31:0] ADMIN_IP = 32'h0A0A0A0A
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic                       in_sop,
   input  logic                       in_eop,
   input  logic [7:0]                 in_data,
   input  logic                       in_side,
   output logic                       verdict_valid,
   output logic [1:0]                 verdict,
   output logic [CNT_W-1:0]           payload_off,
   output logic [15:0]                salt_seed,
   output logic [KEY_W-1:0]           cfg_key,
   output logic [NUM_TGT*TUPLE_W-1:0] cfg_tgt
);
   if (KEY_W < 8 || KEY_W % 8 != 0) begin : g_bad_key
      $error("KEY_W must be a positive multiple of 8");
   end
   if (CNT_W < 8) begin : g_bad_cnt
      $error("CNT_W too small to index the headers");
   end
   if (NUM_TGT < 1) begin : g_bad_tgt
      $error("NUM_TGT must be at least 1");
   end

   logic             take, dec_now, dec_class, is_udp, hit;
   tuple_t           tup;
   logic [15:0]      ident;
   logic [CNT_W-1:0] pay_off;
   verdict_e         kind;

   pkt_cls_parse #(.CNT_W(CNT_W)) u_parse (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
      .in_eop(in_eop), .in_data(in_data), .take(take), .dec_now(dec_now),
      .dec_class(dec_class), .is_udp(is_udp), .tup(tup), .ident(ident),
      .pay_off(pay_off)
   );

   pkt_cls_match #(.NUM_TGT(NUM_TGT)) u_match (
      .pkt(tup), .table_in(cfg_tgt), .hit(hit)
   );

   always_comb begin
      if (!dec_class)                                 kind = VERD_FWD;
      else if (is_udp && tup.dip == ADMIN_IP && !in_side) kind = VERD_ADM;
      else if (hit)                                   kind = in_side ? VERD_DEC : VERD_ENC;
      else                                            kind = VERD_FWD;
   end

   pkt_cls_cfg #(.NUM_TGT(NUM_TGT), .KEY_W(KEY_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .take(take), .in_sop(in_sop), .in_eop(in_eop),
      .in_data(in_data), .start(dec_now && kind == VERD_ADM && !in_eop),
      .key(cfg_key), .tgt(cfg_tgt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         verdict_valid <= 1'b0;
         verdict       <= VERD_FWD;
         payload_off   <= '0;
         salt_seed     <= '0;
      end else begin
         verdict_valid <= dec_now;
         if (dec_now) begin
            verdict     <= kind;
            payload_off <= (kind == VERD_FWD) ? '0 : pay_off;
            salt_seed   <= (kind == VERD_FWD) ? '0 : ident;
         end
      end
   end

   assert_enc_red_side_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (verdict_valid && verdict == VERD_ENC) |-> !$past(in_side));
   assert_dec_black_side_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (verdict_valid && verdict == VERD_DEC) |-> $past(in_side));
   assert_admin_offset_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (verdict_valid && verdict == VERD_ADM) |-> (payload_off >= CNT_W'(42)));
   assert_cfg_after_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(cfg_key) || !$stable(cfg_tgt)) |-> $past(in_valid));
   assert_verdict_after_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
      verdict_valid |-> $past(in_valid));
endmodule

// File: tb/tb_pkt_classifier.sv
module tb_pkt_classifier;
   logic         clk = 1'b0;
   logic         rst_n, in_valid, in_sop, in_eop, in_side;
   logic [7:0]   in_data;
   logic         verdict_valid;
   logic [1:0]   verdict;
   logic [10:0]  payload_off;
   logic [15:0]  salt_seed;
   logic [55:0]  cfg_key;
   logic [287:0] cfg_tgt;

   always #5 clk = ~clk;

   pkt_classifier dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
      .in_eop(in_eop), .in_data(in_data), .in_side(in_side),
      .verdict_valid(verdict_valid), .verdict(verdict), .payload_off(payload_off),
      .salt_seed(salt_seed), .cfg_key(cfg_key), .cfg_tgt(cfg_tgt)
   );

   int checks = 0, fails = 0;
   logic [7:0]  frm [0:255];
   int          flen;
   logic [55:0] m_key = '0;
   logic [95:0] m_tgt [0:2] = '{default: '0};
   int          e_dec, e_off, e_commit;
   logic [1:0]  e_kind;
   logic [15:0] e_salt;
   logic [55:0] n_key;
   logic [95:0] n_tgt [0:2];

   task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic mk_ip(input logic [7:0] proto, input int ihl, input logic [31:0] sip,
                        input logic [31:0] dip, input logic [15:0] sp, input logic [15:0] dp,
                        input logic [15:0] id, input int doff, input int paylen);
      int t, hl;
      t  = 14 + 4*ihl;
      hl = (proto == 8'd17) ? 8 : ((doff < 5) ? 20 : 4*doff);
      flen = t + hl + paylen;
      for (int i = 0; i < 256; i++) frm[i] = 8'(i*7 + 1);
      frm[12] = 8'h08; frm[13] = 8'h00; frm[14] = {4'd4, 4'(ihl)};
      {frm[18], frm[19]} = id; frm[23] = proto;
      {frm[26], frm[27], frm[28], frm[29]} = sip;
      {frm[30], frm[31], frm[32], frm[33]} = dip;
      {frm[t], frm[t+1]} = sp; {frm[t+2], frm[t+3]} = dp;
      if (proto == 8'd6) frm[t+12] = {4'(doff), 4'h0};
   endtask

   task automatic put_admin(input int base, input logic [55:0] k,
                            input logic [95:0] a, input logic [95:0] b, input logic [95:0] c);
      logic [351:0] p;
      p = {k, 8'h5A, a, b, c};
      for (int i = 0; i < 44; i++) frm[base+i] = p[351 - 8*i -: 8];
   endtask

   task automatic model(input bit side);
      int last, t, k, dof;
      logic [95:0] tp;
      last = flen - 1; e_commit = -1; e_kind = 2'd0; e_off = 0; e_salt = '0;
      if (last < 13) e_dec = last;
      else if ({frm[12], frm[13]} != 16'h0800) e_dec = 13;
      else if (last < 14) e_dec = last;
      else if (frm[14][7:4] != 4'd4 || frm[14][3:0] < 4'd5) e_dec = 14;
      else if (last < 23) e_dec = last;
      else if (frm[23] != 8'd6 && frm[23] != 8'd17) e_dec = 23;
      else begin
         t = 14 + 4*int'(frm[14][3:0]);
         k = (frm[23] == 8'd17) ? t + 7 : t + 12;
         if (last < k) e_dec = last;
         else begin
            e_dec = k;
            dof = (frm[23] == 8'd17) ? 2 : int'(frm[k][7:4]);
            if (frm[23] == 8'd17 || dof >= 5) begin
               tp = {frm[26], frm[27], frm[28], frm[29], frm[30], frm[31], frm[32], frm[33],
                     frm[t], frm[t+1], frm[t+2], frm[t+3]};
               if (frm[23] == 8'd17 && tp[63:32] == 32'h0A0A0A0A && !side) begin
                  e_kind = 2'd3;
                  if (last >= t + 51) begin
                     e_commit = t + 51;
                     for (int i = 0; i < 7; i++) n_key[55 - 8*i -: 8] = frm[t+8+i];
                     for (int j = 0; j < 3; j++)
                        for (int i = 0; i < 12; i++) n_tgt[j][95 - 8*i -: 8] = frm[t+16+12*j+i];
                  end
               end else
                  for (int j = 0; j < 3; j++) if (m_tgt[j] == tp) e_kind = side ? 2'd2 : 2'd1;
               if (e_kind != 2'd0) begin
                  e_off  = (frm[23] == 8'd17) ? t + 8 : t + 4*dof;
                  e_salt = {frm[18], frm[19]};
               end
            end
         end
      end
   endtask

   task automatic cmp_cycle(input int last_idx, input string req);
      bit ev;
      if (e_commit >= 0 && last_idx == e_commit) begin
         m_key = n_key;
         for (int j = 0; j < 3; j++) m_tgt[j] = n_tgt[j];
      end
      ev = (last_idx == e_dec);
      chk(verdict_valid == ev, req, "verdict_valid", 128'(verdict_valid), 128'(ev));
      if (ev) begin
         chk(verdict == e_kind, req, "verdict", 128'(verdict), 128'(e_kind));
         chk(int'(payload_off) == e_off, req, "payload_off", 128'(payload_off), 128'(e_off));
         chk(salt_seed == e_salt, req, "salt_seed", 128'(salt_seed), 128'(e_salt));
      end
      chk(cfg_key == m_key, "R8", "cfg_key", 128'(cfg_key), 128'(m_key));
      for (int j = 0; j < 3; j++)
         chk(cfg_tgt[j*96 +: 96] == m_tgt[j], "R8", "cfg_tgt", 128'(cfg_tgt[j*96 +: 96]), 128'(m_tgt[j]));
   endtask

   task automatic send(input bit side, input string req);
      model(side);
      for (int i = 0; i < flen; i++) begin
         @(negedge clk);
         cmp_cycle(i - 1, req);
         in_valid = 1'b1; in_side = side; in_data = frm[i];
         in_sop = (i == 0); in_eop = (i == flen - 1);
      end
      @(negedge clk);
      cmp_cycle(flen - 1, req);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      @(negedge clk);
      cmp_cycle(-7, req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [95:0] ta, tb2, tc;
      rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_side = 1'b0; in_data = '0;
      repeat (3) @(negedge clk);
      chk(verdict_valid == 1'b0, "R1", "reset valid", 128'(verdict_valid), 0);
      chk(cfg_key == '0, "R1", "reset key", 128'(cfg_key), 0);
      chk(cfg_tgt == '0, "R1", "reset table", 128'(cfg_tgt[127:0]), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: wrong ethertype, then wrong IP version
      mk_ip(8'd17, 5, 32'h01020304, 32'h05060708, 16'h1111, 16'h2222, 16'hAAAA, 0, 10);
      frm[12] = 8'h86; frm[13] = 8'hDD;
      send(1'b0, "R2");
      mk_ip(8'd17, 5, 32'h01020304, 32'h05060708, 16'h1111, 16'h2222, 16'hAAAA, 0, 10);
      frm[14] = 8'h65;
      send(1'b0, "R2");
      // R3: ICMP
      mk_ip(8'd1, 5, 32'h01020304, 32'h05060708, 16'h1111, 16'h2222, 16'hAAAA, 0, 10);
      send(1'b0, "R3");
      // R6: no match with empty table
      mk_ip(8'd17, 5, 32'h01020304, 32'h05060708, 16'h1111, 16'h2222, 16'hAAAA, 0, 10);
      send(1'b0, "R6");

      // R7/R8: program the table from the red side
      ta  = {32'hC0A80001, 32'hC0A80102, 16'h0050, 16'h1F90};
      tb2 = {32'h0A000005, 32'h0A000009, 16'h1234, 16'h0016};
      tc  = {32'h08080808, 32'h00000000, 16'h0100, 16'h0400};
      mk_ip(8'd17, 5, 32'hC0A80001, 32'h0A0A0A0A, 16'h4000, 16'h4001, 16'h0BAD, 0, 44);
      put_admin(42, 56'h123456ABCDEF01, ta, tb2, tc);
      send(1'b0, "R7");

      // R4/R6/R10: red UDP matching target 0 -> encrypt
      mk_ip(8'd17, 5, 32'hC0A80001, 32'hC0A80102, 16'h0050, 16'h1F90, 16'hE74B, 0, 20);
      send(1'b0, "R4");
      // R5/R6: black TCP IHL 6, data offset 8, target 1 -> decrypt
      mk_ip(8'd6, 6, 32'h0A000005, 32'h0A000009, 16'h1234, 16'h0016, 16'h3C3C, 8, 16);
      send(1'b1, "R5");
      // R5: TCP data offset 3 -> forward
      mk_ip(8'd6, 5, 32'h0A000005, 32'h0A000009, 16'h1234, 16'h0016, 16'h3C3C, 3, 8);
      send(1'b1, "R5");
      // R6: source port differs -> forward
      mk_ip(8'd17, 5, 32'hC0A80001, 32'hC0A80102, 16'h0051, 16'h1F90, 16'h7777, 0, 8);
      send(1'b0, "R6");
      // R7: admin address from black side -> not a configuration packet
      mk_ip(8'd17, 5, 32'hC0A80001, 32'h0A0A0A0A, 16'h4000, 16'h4001, 16'h0BAD, 0, 44);
      put_admin(42, 56'hFFFFFFFFFFFFFF, tc, tc, tc);
      send(1'b1, "R7");
      // R8: truncated configuration packet leaves the table
      mk_ip(8'd17, 5, 32'hC0A80001, 32'h0A0A0A0A, 16'h4000, 16'h4001, 16'h0BAD, 0, 44);
      put_admin(42, 56'hFFFFFFFFFFFFFF, tc, tc, tc);
      flen = 42 + 30;
      send(1'b0, "R8");
      // R9: frame cut before the deciding byte, and a one-byte frame
      mk_ip(8'd17, 5, 32'hC0A80001, 32'hC0A80102, 16'h0050, 16'h1F90, 16'hE74B, 0, 20);
      flen = 30;
      send(1'b0, "R9");
      flen = 1;
      send(1'b0, "R9");
      // R11: stray bytes outside a frame are ignored
      e_dec = -100; e_commit = -1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         cmp_cycle(-7, "R11");
         in_valid = 1'b1; in_sop = 1'b0; in_eop = (i == 3); in_data = 8'hEE;
      end
      @(negedge clk);
      cmp_cycle(-7, "R11");
      in_valid = 1'b0; in_eop = 1'b0;
      @(negedge clk);
      cmp_cycle(-7, "R11");
      // R8: full replacement, old target 0 no longer matches, IHL 7 admin
      ta = {32'h11111111, 32'h22222222, 16'h0001, 16'h0002};
      mk_ip(8'd17, 7, 32'hC0A80001, 32'h0A0A0A0A, 16'h4000, 16'h4001, 16'h0C0C, 0, 44);
      put_admin(50, 56'h0F0E0D0C0B0A09, ta, ta, ta);
      send(1'b0, "R8");
      mk_ip(8'd17, 5, 32'hC0A80001, 32'hC0A80102, 16'h0050, 16'h1F90, 16'hE74B, 0, 20);
      send(1'b0, "R8");
      mk_ip(8'd17, 5, 32'h11111111, 32'h22222222, 16'h0001, 16'h0002, 16'h5555, 0, 4);
      send(1'b1, "R10");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule